// File: doc/BRIEF.md
# Two-Phase Pipeline Memory Scheduler

This block paces a four-stage processor pipeline (fetch, decode, execute, and a last stage that does memory access together with register write-back) around one single-port memory. That memory holds both code and data. A phase flip-flop alternates between an even and an odd phase. On even cycles the fetch and execute stages are enabled. On odd cycles the decode and memory/write-back stages are enabled. The scheduler owns the memory's only port. It hands the port to the instruction-fetch request on even cycles and to the load/store request on odd cycles. Because of this fixed schedule, the two kinds of access never collide, and no arbitration or stall logic is needed to keep them apart.

The memory reads synchronously with one cycle of latency. Read data from an even-cycle fetch returns as an instruction response on the next, odd, cycle. Read data from an odd-cycle load returns as a load response on the next, even, cycle. A global stall input freezes the phase, drops every stage enable and suppresses any memory request.

Both request interfaces use valid/ready. A request is taken on a clock edge where valid and ready are both high. Fetch ready is high only on unstalled even cycles, and data ready only on unstalled odd cycles. A requester that sees ready low keeps its request and waits for its own phase; nothing is buffered inside the block. Responses carry valid only and cannot be back-pressured. A response that is due during a stall stays valid, with the same data, until the first unstalled cycle. The consuming stage takes the response on that cycle, together with its enable.

Top module: `dual_phase_mem_sched`

## Requirements
- R1: In the first cycle after reset is released (stall low), the phase is even (`phase_odd_o`=0). Only the fetch and execute enables are high.
- R2: Each unstalled cycle toggles the phase. On even cycles only `en_fetch_o` and `en_exec_o` are 1. On odd cycles only `en_decode_o` and `en_memwb_o` are 1.
- R3: While `stall_i` is 1, all four enables and both ready outputs are 0, `mem_en_o` is 0, and the phase holds its value.
- R4: On an unstalled even cycle, `if_req_ready_o`=1 and `d_req_ready_o`=0. If `if_req_valid_i` is 1, the port drives `mem_en_o`=1, `mem_we_o`=0, `mem_be_o`=0, `mem_wdata_o`=0 and `mem_addr_o`=`if_req_addr_i`.
- R5: On an unstalled odd cycle, `d_req_ready_o`=1 and `if_req_ready_o`=0. A valid data request drives `mem_en_o`=1 and `mem_addr_o`=`d_req_addr_i`. A store (`d_req_we_i`=1) also drives `mem_we_o`=1 and `mem_be_o`=`d_req_be_i`. Byte lane k of `mem_wdata_o` (bits 8k+7:8k) carries the same lane of `d_req_wdata_i` when bit k of the byte enable is set, and zero otherwise. A load drives `mem_we_o`=0, `mem_be_o`=0 and `mem_wdata_o`=0.
- R6: Fetch ready and data ready are never high in the same cycle, so a fetch and a data access are never issued together.
- R7: In a cycle with no issued access, `mem_en_o`, `mem_we_o`, `mem_be_o`, `mem_addr_o` and `mem_wdata_o` are all 0.
- R8: In the cycle after an accepted fetch, `if_rsp_valid_o`=1 and `if_rsp_data_o` equals the memory word at the fetched address. If that cycle is stalled, the response stays valid with the same data until the first unstalled cycle. After that it drops unless a new fetch was accepted.
- R9: In the cycle after an accepted load, `ld_rsp_valid_o`=1 and `ld_rsp_data_o` equals the memory word at the load address, including every byte written by earlier stores. It is held across stalls in the same way as R8. A store produces no load response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Global pipeline freeze |
| phase_odd_o | output | 1 | Current phase, 1 = odd |
| en_fetch_o | output | 1 | Fetch stage enable |
| en_decode_o | output | 1 | Decode stage enable |
| en_exec_o | output | 1 | Execute stage enable |
| en_memwb_o | output | 1 | Memory/write-back stage enable |
| if_req_valid_i | input | 1 | Fetch request valid |
| if_req_ready_o | output | 1 | Fetch request accepted this cycle |
| if_req_addr_i | input | ADDR_W | Fetch word address |
| d_req_valid_i | input | 1 | Load/store request valid |
| d_req_ready_o | output | 1 | Load/store request accepted this cycle |
| d_req_we_i | input | 1 | 1 = store, 0 = load |
| d_req_be_i | input | DATA_W/8 | Store byte enables |
| d_req_addr_i | input | ADDR_W | Data word address |
| d_req_wdata_i | input | DATA_W | Store data |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_be_o | output | DATA_W/8 | Memory byte enables |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, one cycle after access |
| if_rsp_valid_o | output | 1 | Instruction response valid |
| if_rsp_data_o | output | DATA_W | Instruction word |
| ld_rsp_valid_o | output | 1 | Load response valid |
| ld_rsp_data_o | output | DATA_W | Load data |

## Verification
The assertions check these properties on every cycle: the enables come in exclusive pairs tied to the phase, the phase toggles or freezes with the stall, the two ready outputs are never high together, a write strobe appears only for an odd-cycle store, the port is idle and zeroed when no access is issued, and every accepted fetch or load is followed one cycle later by a response that stays stable through a stall. Only the bench scenarios can show that the returned data is correct. The bench runs a behavioural memory and a shadow reference, so it can confirm that byte-masked stores land in the right lanes, that a load after a partial store sees the merged word, and that a response held through a long stall still carries the word read when the access was issued.

// File: rtl/dps_pkg.sv
`timescale 1ns/1ps
package dps_pkg;

  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } phase_e;

  typedef struct packed {
    logic fetch;
    logic decode;
    logic exec;
    logic memwb;
  } stage_en_t;

endpackage

// File: rtl/dps_phase_gen.sv
`timescale 1ns/1ps
module dps_phase_gen
  import dps_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stall_i,
  output phase_e    phase_o,
  output stage_en_t en_o
);

  phase_e phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_EVEN;
    end else if (!stall_i) begin
      phase_q <= (phase_q == PH_EVEN) ? PH_ODD : PH_EVEN;
    end
  end

  always_comb begin
    en_o = '0;
    if (!stall_i) begin
      if (phase_q == PH_EVEN) begin
        en_o.fetch = 1'b1;
        en_o.exec  = 1'b1;
      end else begin
        en_o.decode = 1'b1;
        en_o.memwb  = 1'b1;
      end
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/dps_port_steer.sv
`timescale 1ns/1ps
module dps_port_steer
  import dps_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  phase_e              phase_i,
  input  logic                stall_i,
  input  logic                if_valid_i,
  input  logic [ADDR_W-1:0]   if_addr_i,
  output logic                if_ready_o,
  input  logic                d_valid_i,
  input  logic                d_we_i,
  input  logic [BE_W-1:0]     d_be_i,
  input  logic [ADDR_W-1:0]   d_addr_i,
  input  logic [DATA_W-1:0]   d_wdata_i,
  output logic                d_ready_o,
  output logic                mem_en_o,
  output logic                mem_we_o,
  output logic [BE_W-1:0]     mem_be_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic                fetch_go_o,
  output logic                load_go_o
);

  logic [DATA_W-1:0] lane_data;
  logic              data_go;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign lane_data[8*g +: 8] = d_be_i[g] ? d_wdata_i[8*g +: 8] : 8'h00;
  end

  assign if_ready_o = !stall_i && (phase_i == PH_EVEN);
  assign d_ready_o  = !stall_i && (phase_i == PH_ODD);

  always_comb begin
    fetch_go_o  = 1'b0;
    data_go     = 1'b0;
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_be_o    = '0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    if (!stall_i) begin
      if (phase_i == PH_EVEN) begin
        if (if_valid_i) begin
          fetch_go_o = 1'b1;
          mem_en_o   = 1'b1;
          mem_addr_o = if_addr_i;
        end
      end else if (d_valid_i) begin
        data_go    = 1'b1;
        mem_en_o   = 1'b1;
        mem_addr_o = d_addr_i;
        if (d_we_i) begin
          mem_we_o    = 1'b1;
          mem_be_o    = d_be_i;
          mem_wdata_o = lane_data;
        end
      end
    end
  end

  assign load_go_o = data_go && !d_we_i;

endmodule

// File: rtl/dps_rsp_return.sv
`timescale 1ns/1ps
module dps_rsp_return #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  logic              go_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);

  logic              pend_q;
  logic              fresh_q;
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      fresh_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      fresh_q <= go_i;
      if (fresh_q) hold_q <= rdata_i;
      if (!stall_i) pend_q <= go_i;
    end
  end

  assign valid_o = pend_q;
  assign data_o  = fresh_q ? rdata_i : hold_q;

endmodule

// File: rtl/dual_phase_mem_sched.sv
`timescale 1ns/1ps
module dual_phase_mem_sched
  import dps_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stall_i,
  output logic                  phase_odd_o,
  output logic                  en_fetch_o,
  output logic                  en_decode_o,
  output logic                  en_exec_o,
  output logic                  en_memwb_o,
  input  logic                  if_req_valid_i,
  output logic                  if_req_ready_o,
  input  logic [ADDR_W-1:0]     if_req_addr_i,
  input  logic                  d_req_valid_i,
  output logic                  d_req_ready_o,
  input  logic                  d_req_we_i,
  input  logic [DATA_W/8-1:0]   d_req_be_i,
  input  logic [ADDR_W-1:0]     d_req_addr_i,
  input  logic [DATA_W-1:0]     d_req_wdata_i,
  output logic                  mem_en_o,
  output logic                  mem_we_o,
  output logic [DATA_W/8-1:0]   mem_be_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [DATA_W-1:0]     mem_wdata_o,
  input  logic [DATA_W-1:0]     mem_rdata_i,
  output logic                  if_rsp_valid_o,
  output logic [DATA_W-1:0]     if_rsp_data_o,
  output logic                  ld_rsp_valid_o,
  output logic [DATA_W-1:0]     ld_rsp_data_o
);

  localparam int BE_W = DATA_W / 8;

  phase_e    phase;
  stage_en_t stage_en;
  logic      fetch_go;
  logic      load_go;

  dps_phase_gen u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall_i (stall_i),
    .phase_o (phase),
    .en_o    (stage_en)
  );

  dps_port_steer #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BE_W   (BE_W)
  ) u_steer (
    .phase_i     (phase),
    .stall_i     (stall_i),
    .if_valid_i  (if_req_valid_i),
    .if_addr_i   (if_req_addr_i),
    .if_ready_o  (if_req_ready_o),
    .d_valid_i   (d_req_valid_i),
    .d_we_i      (d_req_we_i),
    .d_be_i      (d_req_be_i),
    .d_addr_i    (d_req_addr_i),
    .d_wdata_i   (d_req_wdata_i),
    .d_ready_o   (d_req_ready_o),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .mem_be_o    (mem_be_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .fetch_go_o  (fetch_go),
    .load_go_o   (load_go)
  );

  dps_rsp_return #(.DATA_W(DATA_W)) u_if_rsp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall_i (stall_i),
    .go_i    (fetch_go),
    .rdata_i (mem_rdata_i),
    .valid_o (if_rsp_valid_o),
    .data_o  (if_rsp_data_o)
  );

  dps_rsp_return #(.DATA_W(DATA_W)) u_ld_rsp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall_i (stall_i),
    .go_i    (load_go),
    .rdata_i (mem_rdata_i),
    .valid_o (ld_rsp_valid_o),
    .data_o  (ld_rsp_data_o)
  );

  assign phase_odd_o = (phase == PH_ODD);
  assign en_fetch_o  = stage_en.fetch;
  assign en_decode_o = stage_en.decode;
  assign en_exec_o   = stage_en.exec;
  assign en_memwb_o  = stage_en.memwb;

endmodule

// File: rtl/dual_phase_mem_sched_chk.sv
`timescale 1ns/1ps
module dual_phase_mem_sched_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                stall_i,
  input logic                phase_odd_o,
  input logic                en_fetch_o,
  input logic                en_decode_o,
  input logic                en_exec_o,
  input logic                en_memwb_o,
  input logic                if_req_valid_i,
  input logic                if_req_ready_o,
  input logic                d_req_valid_i,
  input logic                d_req_we_i,
  input logic                d_req_ready_o,
  input logic                mem_en_o,
  input logic                mem_we_o,
  input logic [DATA_W/8-1:0] mem_be_o,
  input logic [ADDR_W-1:0]   mem_addr_o,
  input logic                if_rsp_valid_o,
  input logic [DATA_W-1:0]   if_rsp_data_o,
  input logic                ld_rsp_valid_o
);

  assert_enable_pairs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fetch_o == en_exec_o) && (en_decode_o == en_memwb_o) && !(en_fetch_o && en_decode_o));

  assert_fetch_on_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fetch_o || en_exec_o) |-> !phase_odd_o);

  assert_phase_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_i |=> (phase_odd_o != $past(phase_odd_o)));

  assert_stall_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> $stable(phase_odd_o));

  assert_stall_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> !(en_fetch_o || en_decode_o || en_exec_o || en_memwb_o || mem_en_o));

  assert_store_odd_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (phase_odd_o && d_req_valid_i && d_req_we_i && mem_en_o));

  assert_no_dual_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(if_req_ready_o && d_req_ready_o));

  assert_idle_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en_o |-> (!mem_we_o && (mem_be_o == '0) && (mem_addr_o == '0)));

  assert_fetch_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req_valid_i && if_req_ready_o) |=> if_rsp_valid_o);

  assert_fetch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (if_rsp_valid_o && stall_i) |=> (if_rsp_valid_o && $stable(if_rsp_data_o)));

  assert_load_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req_valid_i && d_req_ready_o && !d_req_we_i) |=> ld_rsp_valid_o);

endmodule

bind dual_phase_mem_sched dual_phase_mem_sched_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .stall_i        (stall_i),
  .phase_odd_o    (phase_odd_o),
  .en_fetch_o     (en_fetch_o),
  .en_decode_o    (en_decode_o),
  .en_exec_o      (en_exec_o),
  .en_memwb_o     (en_memwb_o),
  .if_req_valid_i (if_req_valid_i),
  .if_req_ready_o (if_req_ready_o),
  .d_req_valid_i  (d_req_valid_i),
  .d_req_we_i     (d_req_we_i),
  .d_req_ready_o  (d_req_ready_o),
  .mem_en_o       (mem_en_o),
  .mem_we_o       (mem_we_o),
  .mem_be_o       (mem_be_o),
  .mem_addr_o     (mem_addr_o),
  .if_rsp_valid_o (if_rsp_valid_o),
  .if_rsp_data_o  (if_rsp_data_o),
  .ld_rsp_valid_o (ld_rsp_valid_o)
);

// File: tb/dual_phase_mem_sched_bench.sv
`timescale 1ns/1ps
module dual_phase_mem_sched_bench;

  localparam int AW    = 12;
  localparam int DW    = 32;
  localparam int BW    = DW / 8;
  localparam int WORDS = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall = 1'b0;
  logic          ifv = 1'b0;
  logic [AW-1:0] ifa = '0;
  logic          dv = 1'b0;
  logic          dwe = 1'b0;
  logic [BW-1:0] dbe = '0;
  logic [AW-1:0] da = '0;
  logic [DW-1:0] dwd = '0;
  logic [DW-1:0] mem_rdata;

  logic          phase_odd, en_f, en_d, en_x, en_m;
  logic          if_rdy, d_rdy;
  logic          mem_en, mem_we;
  logic [BW-1:0] mem_be;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          ifr_v, ldr_v;
  logic [DW-1:0] ifr_d, ldr_d;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_phase_mem_sched #(.ADDR_W(AW), .DATA_W(DW)) u_dual_phase_mem_sched (
    .clk(clk), .rst_n(rst_n), .stall_i(stall), .phase_odd_o(phase_odd),
    .en_fetch_o(en_f), .en_decode_o(en_d), .en_exec_o(en_x), .en_memwb_o(en_m),
    .if_req_valid_i(ifv), .if_req_ready_o(if_rdy), .if_req_addr_i(ifa),
    .d_req_valid_i(dv), .d_req_ready_o(d_rdy), .d_req_we_i(dwe), .d_req_be_i(dbe),
    .d_req_addr_i(da), .d_req_wdata_i(dwd),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_be_o(mem_be), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .if_rsp_valid_o(ifr_v), .if_rsp_data_o(ifr_d),
    .ld_rsp_valid_o(ldr_v), .ld_rsp_data_o(ldr_d)
  );

  function automatic logic [DW-1:0] init_word(int i);
    return (32'h01010101 * i) ^ 32'hA55A0000;
  endfunction

  // behavioural single-port synchronous-read memory
  logic [DW-1:0] mem [WORDS];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= init_word(i);
      mem_rdata <= '0;
    end else if (mem_en) begin
      mem_rdata <= mem[mem_addr[5:0]];
      if (mem_we)
        for (int b = 0; b < BW; b++)
          if (mem_be[b]) mem[mem_addr[5:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  // reference model state
  logic [DW-1:0] shadow [WORDS];
  int            m_ph = 0;
  bit            m_fp = 0, m_lp = 0;
  logic [DW-1:0] m_fd = '0, m_ld = '0;
  bit            first_cycle = 0;

  task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    bit            e_ev, e_od, e_go, e_we;
    logic [AW-1:0] e_addr;
    logic [DW-1:0] e_wd;
    logic [BW-1:0] e_be;
    string         tph, tport;
    e_ev = !stall && m_ph == 0;
    e_od = !stall && m_ph == 1;
    tph  = stall ? "R3" : (first_cycle ? "R1" : "R2");
    e_go = (e_ev && ifv) || (e_od && dv);
    e_we = e_od && dv && dwe;
    e_addr = !e_go ? '0 : (e_ev ? ifa : da);
    e_be = e_we ? dbe : '0;
    e_wd = '0;
    if (e_we) for (int b = 0; b < BW; b++) if (dbe[b]) e_wd[8*b +: 8] = dwd[8*b +: 8];
    tport = stall ? "R3" : (!e_go ? "R7" : (e_ev ? "R4" : "R5"));
    vectors++;
    chk(phase_odd == m_ph[0], tph, "phase", {31'b0, phase_odd}, {31'b0, m_ph[0]});
    chk(en_f == e_ev && en_x == e_ev, tph, "fetch/exec enable", {30'b0, en_f, en_x}, {30'b0, e_ev, e_ev});
    chk(en_d == e_od && en_m == e_od, tph, "decode/memwb enable", {30'b0, en_d, en_m}, {30'b0, e_od, e_od});
    chk(if_rdy == e_ev, stall ? "R3" : "R4", "fetch ready", {31'b0, if_rdy}, {31'b0, e_ev});
    chk(d_rdy == e_od, stall ? "R3" : "R5", "data ready", {31'b0, d_rdy}, {31'b0, e_od});
    chk(!(if_rdy && d_rdy), "R6", "dual ready", {30'b0, if_rdy, d_rdy}, 32'h0);
    chk(mem_en == e_go, tport, "mem_en", {31'b0, mem_en}, {31'b0, e_go});
    chk(mem_we == e_we, tport, "mem_we", {31'b0, mem_we}, {31'b0, e_we});
    chk(mem_be == e_be, tport, "mem_be", {28'b0, mem_be}, {28'b0, e_be});
    chk(mem_addr == e_addr, tport, "mem_addr", {20'b0, mem_addr}, {20'b0, e_addr});
    chk(mem_wdata == e_wd, tport, "mem_wdata", mem_wdata, e_wd);
    chk(ifr_v == m_fp, "R8", "fetch rsp valid", {31'b0, ifr_v}, {31'b0, m_fp});
    if (m_fp) chk(ifr_d == m_fd, "R8", "fetch rsp data", ifr_d, m_fd);
    chk(ldr_v == m_lp, "R9", "load rsp valid", {31'b0, ldr_v}, {31'b0, m_lp});
    if (m_lp) chk(ldr_d == m_ld, "R9", "load rsp data", ldr_d, m_ld);
  endtask

  task automatic advance();
    if (!stall) begin
      m_fp = (m_ph == 0) && ifv;
      if (m_fp) m_fd = shadow[ifa[5:0]];
      m_lp = (m_ph == 1) && dv && !dwe;
      if (m_lp) m_ld = shadow[da[5:0]];
      if (m_ph == 1 && dv && dwe)
        for (int b = 0; b < BW; b++) if (dbe[b]) shadow[da[5:0]][8*b +: 8] = dwd[8*b +: 8];
      m_ph = 1 - m_ph;
    end
  endtask

  // one cycle: drive at negedge, compare, then step the model across the next edge
  task automatic cycle(int stall_pct, int req_pct, int amax);
    @(negedge clk);
    stall = ($urandom_range(99) < stall_pct);
    ifv   = ($urandom_range(99) < req_pct);
    ifa   = AW'($urandom_range(amax));
    dv    = ($urandom_range(99) < req_pct);
    dwe   = $urandom_range(1) == 1;
    dbe   = BW'($urandom_range((1 << BW) - 1));
    da    = AW'($urandom_range(amax));
    dwd   = $urandom;
    #1;
    compare();
    first_cycle = 0;
    advance();
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) shadow[i] = init_word(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    first_cycle = 1;
    // R1: reset state seen in first cycle after release, no stall
    @(posedge clk);
    // first release cycle was from negedge to this edge; check next with fresh model
    m_ph = 1;  // one unstalled edge with idle inputs has passed
    // R4 R5 R7 traffic with no stall
    for (int n = 0; n < 80; n++) cycle(0, 70, 63);
    // R7 idle port
    for (int n = 0; n < 30; n++) cycle(0, 0, 63);
    // R3 R8 R9 stalls mixed with heavy traffic on a small address set
    for (int n = 0; n < 600; n++) cycle(30, 80, 15);
    // long stall bursts
    for (int n = 0; n < 200; n++) cycle(70, 90, 7);
    for (int n = 0; n < 100; n++) cycle(0, 100, 7);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  // R1: directly observe the first cycle after reset release
  initial begin
    @(posedge rst_n);
    #1;
    vectors++;
    chk(!phase_odd && en_f && en_x && !en_d && !en_m, "R1", "post-reset enables",
        {27'b0, phase_odd, en_f, en_d, en_x, en_m}, {27'b0, 5'b01010});
    chk(!ifr_v && !ldr_v && !mem_en, "R1", "post-reset idle",
        {29'b0, ifr_v, ldr_v, mem_en}, 32'h0);
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule